// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a two-wire (I2C) slave that fronts a byte-wide memory addressed by a 17-bit pointer, split into two 64K halves. It runs on a system clock that is much faster than SCL. SCL and SDA are resynchronized inside the block, and Start, Stop and the clock edges are detected from the synchronized samples. SDA leaves the block as a single drive-low output, which the pad turns into an open-drain driver. Two strap inputs select one of four addresses on a shared bus. A write-lock input blocks every change to the array and leaves reads untouched.

A write transfer sends a control byte, two address bytes and any number of data bytes. The data bytes fill a 128-byte page buffer. The buffer is copied into the array after the Stop, by a scan that takes one system clock per page slot. While that scan runs, the block does not answer its control byte, so a host can poll for completion. A read transfer returns the byte at the pointer and then advances it. Three reads are supported. A current-address read uses the pointer as it stands. A random read sends the address as a write and then issues a repeated Start. A sequential read continues for as long as the host acknowledges each byte.

The pointer is 17 bits wide. The storage behind it is a parameter: bit 16 selects a bank, and `STORE_LOW_W` low bits index inside that bank. With `STORE_LOW_W` = 16 the full 128K bytes exist. With a smaller value, higher pointer bits alias.

Top module: `i2cmem_slave`

## Requirements
- R1: Control byte, MSB first. Bits 7:4 must equal 1010. Bit 3 must equal `sel_hi_i` and bit 2 must equal `sel_lo_i`. When all of these match, the block drives SDA low during the ninth clock. When they do not match, it leaves SDA released until the next Start.
- R2: In write mode (control bit 0 = 0), control bit 1 loads pointer bit 16. The next byte loads pointer bits 15:8 and the byte after it loads bits 7:0. Both address bytes are acknowledged even when `write_lock_i` is high.
- R3: With the lock low, every data byte after the address is acknowledged and buffered. Each is written to the array after the Stop. A later read returns the written value.
- R4: During a write, only the low 7 pointer bits advance. They wrap from 7Fh to 00h inside the same 128-byte page.
- R5: With `write_lock_i` high, data bytes are not acknowledged and the array keeps its contents. Reads return correct data whatever the level of `write_lock_i`.
- R6: A read-mode control byte (bit 0 = 1) returns the byte at the current pointer and then advances the pointer by one. Its bit 1 does not change pointer bit 16.
- R7: Random read: a repeated Start after the two address bytes ends the write phase and writes nothing. The read that follows returns the byte at the loaded address.
- R8: When the host acknowledges a read byte, the block sends the next byte. When the host does not acknowledge, the block releases SDA and waits for a Stop or a Start. The block never drives SDA during the host's acknowledge slot.
- R9: During a read, the pointer advances within its 64K half. 0FFFFh is followed by 00000h, and 1FFFFh is followed by 10000h.
- R10: While the buffered bytes are being copied into the array, a matching control byte is not acknowledged.
- R11: After reset SDA is released. The SDA drive is only ever asserted while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Sampled level of the serial data line |
| sda_drive_low_o | output | 1 | 1 pulls the serial data line low |
| sel_lo_i | input | 1 | Address strap compared with control bit 2 |
| sel_hi_i | input | 1 | Address strap compared with control bit 3 |
| write_lock_i | input | 1 | 1 blocks all array writes |

## Verification
The assertions assume that SCL and SDA follow the bus rules. SDA may change only while SCL is low, except when the host makes a Start or a Stop. Each SCL level must last several system clocks, so that the synchronizer sees every edge. They also assume that the straps and the lock input stay steady while a byte is being transferred. The bench master changes SDA two clocks after each SCL fall. It holds each SCL level for 8 system clocks, or for 4 in the completion-polling test. It changes straps and lock only between transfers, which keeps the stimulus inside these assumptions.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

  localparam int PTR_W = 17;
  localparam logic [3:0] CTRL_TAG = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTRL,
    ST_CTRL_ACK,
    ST_ADRH,
    ST_ADRH_ACK,
    ST_ADRL,
    ST_ADRL_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } st_t;

endpackage

// File: rtl/i2cmem_bus_sync.sv
module i2cmem_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);

  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  // idle bus level is high, so the chain resets to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s    = scl_sh[STAGES-1];
  assign sda_s    = sda_sh[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  // SDA edges while SCL stays high in both samples
  assign start_p  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_p   = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2cmem_store.sv
module i2cmem_store #(
  parameter int PTR_W  = 17,
  parameter int LOW_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [PTR_W-1:0] raddr,
  output logic [7:0]       rdata
);

  localparam int DEPTH = 1 << LOW_W;
  localparam int NBANK = 2;

  logic [7:0] bank_q [NBANK];
  logic       sel_q;

  // one bank per 64K half, selected by the top pointer bit
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [7:0] mem [DEPTH];
    logic [7:0] q;
    logic       hit;
    assign hit = we && (waddr[PTR_W-1] == 1'(b));
    always_ff @(posedge clk) begin
      if (hit) begin
        mem[waddr[LOW_W-1:0]] <= wdata;
      end
      q <= mem[raddr[LOW_W-1:0]];
    end
    assign bank_q[b] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
    end else begin
      sel_q <= raddr[PTR_W-1];
    end
  end

  assign rdata = bank_q[sel_q];

endmodule

// File: rtl/i2cmem_page_buf.sv
module i2cmem_page_buf #(
  parameter int PAGE_W = 7,
  parameter int PTR_W  = 17
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [PAGE_W-1:0]       wr_idx,
  input  logic [7:0]              wr_data,
  input  logic                    clear,
  input  logic                    commit,
  input  logic [PTR_W-PAGE_W-1:0] base,
  output logic                    any_valid,
  output logic                    busy,
  output logic                    mem_we,
  output logic [PTR_W-1:0]        mem_addr,
  output logic [7:0]              mem_data
);

  localparam int DEPTH  = 1 << PAGE_W;
  localparam int BASE_W = PTR_W - PAGE_W;
  localparam logic [PAGE_W-1:0] LAST = {PAGE_W{1'b1}};
  localparam logic [PAGE_W-1:0] ONE  = {{(PAGE_W-1){1'b0}}, 1'b1};

  logic [7:0]        data_q [DEPTH];
  logic [DEPTH-1:0]  valid_q, valid_d;
  logic              busy_q, busy_d;
  logic [PAGE_W-1:0] cnt_q, cnt_d;
  logic [BASE_W-1:0] base_q, base_d;
  logic              done;
  logic              wr_ok;

  assign wr_ok = wr_en && !busy_q;

  always_comb begin
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    base_d  = base_q;
    done    = busy_q && (cnt_q == LAST);
    if (!busy_q && commit) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      base_d = base;
    end else if (busy_q) begin
      cnt_d = cnt_q + ONE;
      if (done) begin
        busy_d = 1'b0;
      end
    end
    valid_d = valid_q;
    if (wr_ok) begin
      valid_d[wr_idx] = 1'b1;
    end
    if (done || (clear && !busy_q)) begin
      valid_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      base_q  <= '0;
      valid_q <= '0;
    end else begin
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      base_q  <= base_d;
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      data_q[wr_idx] <= wr_data;
    end
  end

  assign any_valid = |valid_q;
  assign busy      = busy_q;
  assign mem_we    = busy_q && valid_q[cnt_q];
  assign mem_addr  = {base_q, cnt_q};
  assign mem_data  = data_q[cnt_q];

endmodule

// File: rtl/i2cmem_slave.sv
module i2cmem_slave
  import i2cmem_pkg::*;
#(
  parameter int PAGE_W      = 7,
  parameter int STORE_LOW_W = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_drive_low_o,
  input  logic sel_lo_i,
  input  logic sel_hi_i,
  input  logic write_lock_i
);

  localparam int BASE_W = PTR_W - PAGE_W;
  localparam logic [PAGE_W-1:0] PG_ONE = {{(PAGE_W-1){1'b0}}, 1'b1};
  localparam logic [3:0] BITS = 4'd8;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync;
  logic       rst_n;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_n = rst_sync[1];

  logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;

  i2cmem_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p)
  );

  st_t              st_q, st_d;
  logic [3:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             drv_q, drv_d;
  logic             rw_q, rw_d;
  logic             mack_q, mack_d;

  logic             pb_wr, pb_any, pb_busy, pb_clear, pb_commit;
  logic             mem_we;
  logic [PTR_W-1:0] mem_addr;
  logic [7:0]       mem_wdata, rd_data;
  logic             ctrl_hit;

  i2cmem_store #(.PTR_W(PTR_W), .LOW_W(STORE_LOW_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .waddr (mem_addr),
    .wdata (mem_wdata),
    .raddr (ptr_q),
    .rdata (rd_data)
  );

  assign pb_commit = stop_p && !write_lock_i && pb_any;
  assign pb_clear  = start_p || (stop_p && (write_lock_i || !pb_any));

  i2cmem_page_buf #(.PAGE_W(PAGE_W), .PTR_W(PTR_W)) u_page (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (pb_wr),
    .wr_idx    (ptr_q[PAGE_W-1:0]),
    .wr_data   (sh_q),
    .clear     (pb_clear),
    .commit    (pb_commit),
    .base      (ptr_q[PTR_W-1:PAGE_W]),
    .any_valid (pb_any),
    .busy      (pb_busy),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_data  (mem_wdata)
  );

  assign ctrl_hit = (sh_q[7:4] == CTRL_TAG) && (sh_q[3] == sel_hi_i) &&
                    (sh_q[2] == sel_lo_i) && !pb_busy;

  always_comb begin
    st_d   = st_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    ptr_d  = ptr_q;
    drv_d  = drv_q;
    rw_d   = rw_q;
    mack_d = mack_q;
    pb_wr  = 1'b0;
    if (start_p) begin
      st_d  = ST_CTRL;
      bit_d = '0;
      drv_d = 1'b0;
    end else if (stop_p) begin
      st_d  = ST_IDLE;
      drv_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_CTRL, ST_ADRH, ST_ADRL, ST_WDATA: begin
          if (scl_rise && bit_q != BITS) begin
            sh_d  = {sh_q[6:0], sda_s};
            bit_d = bit_q + 4'd1;
          end else if (scl_fall && bit_q == BITS) begin
            bit_d = '0;
            if (st_q == ST_CTRL) begin
              if (ctrl_hit) begin
                drv_d = 1'b1;
                st_d  = ST_CTRL_ACK;
                rw_d  = sh_q[0];
                if (!sh_q[0]) begin
                  ptr_d[PTR_W-1] = sh_q[1];
                end
              end else begin
                st_d = ST_IDLE;
              end
            end else if (st_q == ST_ADRH) begin
              drv_d        = 1'b1;
              st_d         = ST_ADRH_ACK;
              ptr_d[15:8]  = sh_q;
            end else if (st_q == ST_ADRL) begin
              drv_d        = 1'b1;
              st_d         = ST_ADRL_ACK;
              ptr_d[7:0]   = sh_q;
            end else begin
              st_d = ST_WDATA_ACK;
              if (!write_lock_i) begin
                drv_d = 1'b1;
                pb_wr = 1'b1;
                ptr_d[PAGE_W-1:0] = ptr_q[PAGE_W-1:0] + PG_ONE;
              end
            end
          end
        end
        ST_CTRL_ACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              sh_d        = rd_data;
              drv_d       = ~rd_data[7];
              bit_d       = 4'd1;
              st_d        = ST_RDATA;
              ptr_d[15:0] = ptr_q[15:0] + 16'd1;
            end else begin
              drv_d = 1'b0;
              st_d  = ST_ADRH;
            end
          end
        end
        ST_ADRH_ACK: begin
          if (scl_fall) begin
            drv_d = 1'b0;
            st_d  = ST_ADRL;
          end
        end
        ST_ADRL_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            drv_d = 1'b0;
            st_d  = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bit_q == BITS) begin
              drv_d = 1'b0;
              st_d  = ST_RACK;
            end else begin
              sh_d  = {sh_q[6:0], 1'b0};
              drv_d = ~sh_q[6];
              bit_d = bit_q + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              sh_d        = rd_data;
              drv_d       = ~rd_data[7];
              bit_d       = 4'd1;
              st_d        = ST_RDATA;
              ptr_d[15:0] = ptr_q[15:0] + 16'd1;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: begin
          st_d = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      sh_q   <= '0;
      ptr_q  <= '0;
      drv_q  <= 1'b0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      ptr_q  <= ptr_d;
      drv_q  <= drv_d;
      rw_q   <= rw_d;
      mack_q <= mack_d;
    end
  end

  assign sda_drive_low_o = drv_q;

endmodule

// File: rtl/i2cmem_slave_chk.sv
module i2cmem_slave_chk
  import i2cmem_pkg::*;
(
  input logic clk,
  input logic rst_ni,
  input logic wp,
  input logic scl_s,
  input logic drive_low,
  input st_t  st,
  input logic ptr_top,
  input logic commit_busy
);

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_ni) (st == ST_IDLE) |-> !drive_low); // R1

  AST_DRIVE_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_ni) $rose(drive_low) |-> !scl_s); // R11

  AST_NO_COMMIT_LOCKED: assert property (@(posedge clk) disable iff (!rst_ni) $rose(commit_busy) |-> !$past(wp)); // R5

  AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_ni) (st == ST_CTRL_ACK && drive_low) |-> !commit_busy); // R10

  AST_HALF_FIXED: assert property (@(posedge clk) disable iff (!rst_ni) !$stable(ptr_top) |-> (st == ST_CTRL_ACK)); // R9

  AST_HOST_ACK_SLOT: assert property (@(posedge clk) disable iff (!rst_ni) (st == ST_RACK) |-> !drive_low); // R8

endmodule

bind i2cmem_slave i2cmem_slave_chk u_chk (
  .clk         (clk),
  .rst_ni      (rst_ni),
  .wp          (write_lock_i),
  .scl_s       (scl_s),
  .drive_low   (sda_drive_low_o),
  .st          (st_q),
  .ptr_top     (ptr_q[16]),
  .commit_busy (pb_busy)
);

// File: tb/i2cmem_slave_tb.sv
`timescale 1ns/1ps
module i2cmem_slave_tb;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sel_lo = 1'b0;
  logic sel_hi = 1'b0;
  logic lock = 1'b0;
  logic dut_low;
  logic sda;
  assign sda = ~(m_low | dut_low);

  i2cmem_slave u_dut (
    .clk             (clk),
    .rst_ni          (rst_ni),
    .scl_i           (scl),
    .sda_i           (sda),
    .sda_drive_low_o (dut_low),
    .sel_lo_i        (sel_lo),
    .sel_hi_i        (sel_hi),
    .write_lock_i    (lock)
  );

  int n_chk = 0;
  int n_fail = 0;
  int half = 8;
  bit done = 1'b0;

  // address, data
  localparam logic [24:0] VEC [6] = '{
    {17'h00010, 8'h5A},
    {17'h10010, 8'hA5},
    {17'h0ABCD, 8'h3C},
    {17'h1FFFF, 8'hC3},
    {17'h00000, 8'h77},
    {17'h0FFFF, 8'hE1}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    m_low = 1'b0; tick(half);
    scl = 1'b1;   tick(half);
    m_low = 1'b1; tick(half);
    scl = 1'b0;   tick(2);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; tick(half);
    scl = 1'b1;   tick(half);
    m_low = 1'b0; tick(half);
  endtask

  task automatic put_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; tick(half);
      scl = 1'b1;    tick(half);
      scl = 1'b0;    tick(2);
    end
    m_low = 1'b0; tick(half);
    scl = 1'b1;   tick(half / 2);
    acked = (sda === 1'b0);
    tick(half - half / 2);
    scl = 1'b0;   tick(2);
  endtask

  task automatic get_byte(output logic [7:0] b, input bit ack);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(half);
      scl = 1'b1; tick(half / 2);
      b[i] = sda;
      tick(half - half / 2);
      scl = 1'b0; tick(2);
    end
    m_low = ack; tick(half);
    scl = 1'b1;  tick(half);
    scl = 1'b0;  tick(2);
    m_low = 1'b0;
  endtask

  task automatic addr_phase(input logic [16:0] a, input string tag);
    bit k;
    bus_start();
    put_byte({4'hA, sel_hi, sel_lo, a[16], 1'b0}, k);
    check_eq({tag, " control ack"}, {31'd0, k}, 32'd1);
    put_byte(a[15:8], k);
    check_eq({tag, " R2 high address ack"}, {31'd0, k}, 32'd1);
    put_byte(a[7:0], k);
    check_eq({tag, " R2 low address ack"}, {31'd0, k}, 32'd1);
  endtask

  task automatic write_bytes(input logic [16:0] a, input int n, input logic [31:0] d, input string tag);
    bit k;
    addr_phase(a, tag);
    for (int i = 0; i < n; i++) begin
      put_byte(d[31-8*i -: 8], k);
      check_eq({tag, " R3 data ack"}, {31'd0, k}, 32'd1);
    end
    bus_stop();
    tick(400);
  endtask

  task automatic rand_read(input logic [16:0] a, input int n, output logic [31:0] got, input string tag);
    bit k;
    logic [7:0] b;
    got = '0;
    addr_phase(a, tag);
    bus_start();
    put_byte({4'hA, sel_hi, sel_lo, a[16], 1'b1}, k);
    check_eq({tag, " R7 read control ack"}, {31'd0, k}, 32'd1);
    for (int i = 0; i < n; i++) begin
      get_byte(b, i != n - 1);
      got[31-8*i -: 8] = b;
    end
    bus_stop();
    tick(20);
  endtask

  task automatic cur_read(input bit blk, output logic [7:0] b, input string tag);
    bit k;
    bus_start();
    put_byte({4'hA, sel_hi, sel_lo, blk, 1'b1}, k);
    check_eq({tag, " R6 control ack"}, {31'd0, k}, 32'd1);
    get_byte(b, 1'b0);
    bus_stop();
    tick(20);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    logic [31:0] got;
    logic [7:0]  b;
    bit          k;

    rst_ni = 1'b0;
    tick(10);
    check_eq("R11 reset drive", {31'd0, dut_low}, 32'd0);
    rst_ni = 1'b1;
    tick(10);
    check_eq("R11 drive after reset", {31'd0, dut_low}, 32'd0);

    // table: byte write then random read back of each entry
    for (int v = 0; v < 6; v++) begin
      write_bytes(VEC[v][24:8], 1, {VEC[v][7:0], 24'd0}, "R3 table");
      rand_read(VEC[v][24:8], 1, got, "R7 table");
      check_eq("R3 R7 table readback", {24'd0, got[31:24]}, {24'd0, VEC[v][7:0]});
    end

    // page write in the upper half
    write_bytes(17'h10000, 4, 32'h11223344, "R3 page");

    // pointer after reading 0FFFFh wraps to 00000h; control bit 1 ignored
    rand_read(17'h0FFFF, 1, got, "R9 low half");
    check_eq("R7 read 0FFFFh", {24'd0, got[31:24]}, 32'hE1);
    cur_read(1'b1, b, "R6 current");
    check_eq("R9 R6 wrap to 00000h, bit16 kept", {24'd0, b}, 32'h77);

    // sequential read across 1FFFFh
    rand_read(17'h1FFFF, 3, got, "R8 sequential");
    check_eq("R8 R9 sequential from 1FFFFh", {8'd0, got[31:8]}, 32'h00C31122);
    cur_read(1'b0, b, "R6 after sequential");
    check_eq("R6 current after sequential", {24'd0, b}, 32'h33);

    // page wrap of the low 7 bits
    write_bytes(17'h0007E, 4, 32'h91929394, "R4 page wrap");
    rand_read(17'h00000, 2, got, "R4 wrapped");
    check_eq("R4 bytes landed at 00000h", {16'd0, got[31:16]}, 32'h9394);
    rand_read(17'h0007E, 2, got, "R4 page end");
    check_eq("R4 bytes at 7Eh", {16'd0, got[31:16]}, 32'h9192);

    // write lock
    lock = 1'b1;
    tick(4);
    addr_phase(17'h00010, "R5 locked");
    put_byte(8'hEE, k);
    check_eq("R5 data nack when locked", {31'd0, k}, 32'd0);
    bus_stop();
    tick(400);
    rand_read(17'h00010, 1, got, "R5 read locked");
    check_eq("R5 array unchanged, read allowed", {24'd0, got[31:24]}, 32'h5A);
    lock = 1'b0;

    // strap selection
    sel_hi = 1'b1;
    sel_lo = 1'b0;
    tick(4);
    bus_start();
    put_byte({4'hA, 1'b0, 1'b0, 1'b0, 1'b1}, k);
    check_eq("R1 straps 00 vs 10 nack", {31'd0, k}, 32'd0);
    tick(2);
    check_eq("R1 released after mismatch", {31'd0, dut_low}, 32'd0);
    bus_stop();
    bus_start();
    put_byte({4'hA, 1'b0, 1'b1, 1'b0, 1'b1}, k);
    check_eq("R1 straps 01 vs 10 nack", {31'd0, k}, 32'd0);
    bus_stop();
    bus_start();
    put_byte({4'h5, 1'b1, 1'b0, 1'b0, 1'b1}, k);
    check_eq("R1 wrong tag nack", {31'd0, k}, 32'd0);
    bus_stop();
    rand_read(17'h10010, 1, got, "R1 matched");
    check_eq("R1 matched straps read", {24'd0, got[31:24]}, 32'hA5);
    sel_hi = 1'b0;
    tick(4);

    // completion polling during the copy to the array
    half = 4;
    addr_phase(17'h0ABCD, "R10 write");
    put_byte(8'h42, k);
    check_eq("R10 R3 data ack", {31'd0, k}, 32'd1);
    bus_stop();
    bus_start();
    put_byte({4'hA, 1'b0, 1'b0, 1'b0, 1'b0}, k);
    check_eq("R10 nack while copying", {31'd0, k}, 32'd0);
    bus_stop();
    half = 8;
    tick(400);
    rand_read(17'h0ABCD, 1, got, "R10 after copy");
    check_eq("R10 R3 data after copy", {24'd0, got[31:24]}, 32'h42);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

endmodule